// File: doc/BRIEF.md
# Local Timeline Event Scheduler

This block produces timing events on its own, with no external timing stream. While enabled it counts microsecond ticks since the last reset event and walks a table of up to 64 (time, event code) entries, sorted by ascending time. When the time of the entry under the pointer has been reached, that entry's code is offered to the serial encoder. When the count reaches the programmed cycle length, the block offers the programmable reset event code instead. It then returns the count and the pointer to zero, so the timeline starts again.

Events leave through a one-deep output slot with a valid/ready handshake. An entry that cannot leave because the slot is full stays pending and is sent on a later tick. A blocked reset event is held and sent in the first cycle the slot frees. The table can be written only while the scheduler is disabled. The tick input is a one-cycle strobe at 1 MHz, derived upstream from whichever 10 MHz reference has been selected.

Top module: `tl_scheduler`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `ev_valid` is 0 and the count and the table pointer are held at 0. Enabling starts the timeline at count 0 with no reset event.
- R2: Each `tick_us` while enabled advances the count by one. A tick that finds the count equal to `cycle_len` L returns the count to 0. Reset events are therefore L+1 ticks apart, and the first one comes on the (L+1)-th tick after enabling.
- R3: On a tick whose count is not equal to L, the entry under the pointer is emitted if its index is below `num_entries` and its time is less than or equal to the count. The pointer then advances by one. At most one event is emitted per tick.
- R4: Entries that share a time are emitted on consecutive ticks, in table order.
- R5: At the end-of-cycle tick the reset event takes priority, `ev_code` equals `reset_code`, and the pointer returns to entry 0. An entry whose time is L or greater is never emitted.
- R6: `ev_valid` stays high with `ev_code` unchanged until a cycle with `ev_ready` high. With `ev_ready` held high, each event appears for exactly one clock cycle.
- R7: If a due entry meets a full output slot, the pointer does not advance, and the entry is emitted on the first later tick that finds the slot free.
- R8: A reset event that meets a full slot is held pending and is loaded in the first cycle the slot frees, whether or not a tick occurs. No entry is emitted while a reset event is pending.
- R9: A table write (`wr_en`) made while `enable` is high does not change the table. The event later emitted for that entry keeps its old code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Scheduler run; low clears the timeline and unlocks the table |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| cycle_len | input | 32 | Count at which the reset event fires |
| reset_code | input | 8 | Code sent as the reset event |
| num_entries | input | 7 | Number of table entries in use (0..64) |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table entry written |
| wr_time | input | 32 | Time offset for the entry written |
| wr_code | input | 8 | Event code for the entry written |
| ev_ready | input | 1 | Encoder accepts the event |
| ev_valid | output | 1 | Event offered to the encoder |
| ev_code | output | 8 | Event code offered |

## Verification
The reset event and a table entry can both claim the same tick: an entry with time equal to the cycle length, or a due entry stalled behind a busy slot when the cycle ends. Table sweeps that place an entry at the cycle length test the first case, and the bench expects the reset code and never that entry. The second case is provoked by holding `ev_ready` low across the end-of-cycle tick. The bench then expects the old event to stay, the reset code to appear in the first cycle `ev_ready` rises with no tick present, and the entry at time 1 to return only after the new timeline reaches count 1.

// File: rtl/tl_pkg.sv
// Package: shared types for the local timeline scheduler.
// Assumes: nothing beyond standard SystemVerilog.
package tl_pkg;
    // Source of the event loaded into the output slot in a cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ENTRY = 2'd1,
        SRC_RESET = 2'd2
    } tl_src_e;
endpackage

// File: rtl/tl_table.sv
// Module: tl_table
// Holds the (time, code) schedule. Writes are refused while locked.
// Assumes: the caller keeps its own count of valid entries; contents are not
// cleared by reset, and entries must be written before use.
module tl_table #(
    parameter int TIME_W = 32,
    parameter int EV_W   = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [EV_W-1:0]   wr_code,
    input  logic [AW-1:0]     rd_addr,
    output logic [TIME_W-1:0] rd_time,
    output logic [EV_W-1:0]   rd_code
);
    logic [TIME_W-1:0] time_mem [DEPTH];
    logic [EV_W-1:0]   code_mem [DEPTH];

    // Store an entry only while the scheduler is stopped
    always_ff @(posedge clk) begin
        if (wr_en && !lock) begin
            time_mem[wr_addr] <= wr_time;
            code_mem[wr_addr] <= wr_code;
        end
    end

    // Combinational read of the entry under the pointer
    always_comb begin
        rd_time = time_mem[rd_addr];
        rd_code = code_mem[rd_addr];
    end
endmodule

// File: rtl/tl_timebase.sv
// Module: tl_timebase
// Microsecond count since the last reset event; wraps to zero at the end tick.
// Assumes: tick is a single-cycle strobe; cycle_len is stable while running.
module tl_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [TIME_W-1:0] cycle_len,
    output logic [TIME_W-1:0] now,
    output logic              at_end
);
    // End of cycle reached when the count equals the programmed length
    always_comb at_end = (now == cycle_len);

    // Count ticks, restart after the end tick, hold at zero when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            now <= '0;
        else if (tick)
            now <= at_end ? '0 : now + TIME_W'(1);
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick)) |-> $stable(now));
endmodule

// File: rtl/tl_slot.sv
// Module: tl_slot
// One-deep output register with valid/ready handshake toward the encoder.
// Assumes: load is raised only when free is high.
module tl_slot #(
    parameter int EV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            load,
    input  logic [EV_W-1:0] load_code,
    input  logic            ready,
    output logic            valid,
    output logic [EV_W-1:0] code,
    output logic            free
);
    // Slot can take a new event if empty or being drained this cycle
    always_comb free = !valid || ready;

    // Load, drain or clear the held event
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            valid <= 1'b0;
            code  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            code  <= load_code;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && valid && !ready) |=> (!run || (valid && $stable(code))));
endmodule

// File: rtl/tl_scheduler.sv
// Module: tl_scheduler (top)
// Walks a sorted event table against a microsecond timeline, issuing one event
// per tick and a reset event at the end of each cycle.
// Assumes: table sorted by ascending time; tick_us is a one-cycle 1 MHz strobe.
module tl_scheduler
    import tl_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int EV_W   = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick_us,
    input  logic [TIME_W-1:0] cycle_len,
    input  logic [EV_W-1:0]   reset_code,
    input  logic [PW-1:0]     num_entries,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [EV_W-1:0]   wr_code,
    input  logic              ev_ready,
    output logic              ev_valid,
    output logic [EV_W-1:0]   ev_code
);
    logic [TIME_W-1:0] now;
    logic              at_end;
    logic [PW-1:0]     ptr;
    logic [TIME_W-1:0] ent_time;
    logic [EV_W-1:0]   ent_code;
    logic              slot_free;
    logic              rst_pend;
    logic              end_tick;
    logic              entry_due;
    tl_src_e           src;

    tl_table #(.TIME_W(TIME_W), .EV_W(EV_W), .DEPTH(DEPTH)) u_table (
        .clk(clk), .lock(enable), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_time(wr_time), .wr_code(wr_code), .rd_addr(ptr[AW-1:0]),
        .rd_time(ent_time), .rd_code(ent_code)
    );

    tl_timebase #(.TIME_W(TIME_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick_us),
        .cycle_len(cycle_len), .now(now), .at_end(at_end)
    );

    // End-of-cycle tick and whether the pointed entry is due
    always_comb begin
        end_tick  = enable && tick_us && at_end;
        entry_due = (ptr < num_entries) && (ent_time <= now);
    end

    // Choose what enters the output slot: pending/end reset first, then entry
    always_comb begin
        src = SRC_NONE;
        if (enable && slot_free) begin
            if (rst_pend || end_tick)
                src = SRC_RESET;
            else if (tick_us && entry_due)
                src = SRC_ENTRY;
        end
    end

    // Remember a reset event that met a full slot
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            rst_pend <= 1'b0;
        else if (src == SRC_RESET)
            rst_pend <= 1'b0;
        else if (end_tick)
            rst_pend <= 1'b1;
    end

    // Table pointer: restart at cycle end, advance on each emitted entry
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            ptr <= '0;
        else if (end_tick)
            ptr <= '0;
        else if (src == SRC_ENTRY)
            ptr <= ptr + PW'(1);
    end

    tl_slot #(.EV_W(EV_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .run(enable),
        .load(src != SRC_NONE),
        .load_code((src == SRC_RESET) ? reset_code : ent_code),
        .ready(ev_ready), .valid(ev_valid), .code(ev_code), .free(slot_free)
    );

    // R1
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ev_valid && now == '0 && ptr == '0));
    // R5
    ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_tick |=> (!enable || ptr == '0));
    // R8
    pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rst_pend && slot_free) |=>
            (!enable || (ev_valid && ev_code == $past(reset_code))));
endmodule

// File: tb/tl_scheduler_test.sv
`timescale 1ns/1ps
module tl_scheduler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        tick_us = 1'b0;
    logic [31:0] cycle_len = '0;
    logic [7:0]  reset_code = '0;
    logic [6:0]  num_entries = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_time = '0;
    logic [7:0]  wr_code = '0;
    logic        ev_ready = 1'b1;
    logic        ev_valid;
    logic [7:0]  ev_code;

    int checks = 0;
    int errors = 0;
    int m_time [64];
    int m_code [64];
    int m_now, m_ptr, m_len, m_n, m_rst;

    always #5 clk = ~clk;

    tl_scheduler uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_us(tick_us),
        .cycle_len(cycle_len), .reset_code(reset_code), .num_entries(num_entries),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_time(wr_time), .wr_code(wr_code),
        .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_code(ev_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int a, input int t, input int c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_time = 32'(t); wr_code = 8'(c);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One-cycle tick; returns at the negedge after the sampling edge
    task automatic pulse;
        @(negedge clk) tick_us = 1'b1;
        @(negedge clk) tick_us = 1'b0;
    endtask

    // Tick with ready high, compared against the arithmetic model
    task automatic model_tick;
        int exp_v, exp_c;
        exp_v = 0; exp_c = 0;
        if (m_now == m_len) begin
            exp_v = 1; exp_c = m_rst; m_now = 0; m_ptr = 0;   // R5 reset wins
        end else begin
            if (m_ptr < m_n && m_time[m_ptr] <= m_now) begin
                exp_v = 1; exp_c = m_code[m_ptr]; m_ptr++;    // R3 R4
            end
            m_now++;
        end
        pulse();
        chk(ev_valid == exp_v[0], "R2/R3 valid", ev_valid, exp_v);
        if (exp_v != 0) chk(ev_code == exp_c[7:0], "R3/R4/R5/R9 code", ev_code, exp_c);
        @(negedge clk);
        chk(ev_valid == 1'b0, "R6 single-cycle pulse", ev_valid, 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ev_valid == 1'b0, "R1 reset state", ev_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ev_valid == 1'b0, "R1 idle while disabled", ev_valid, 0);

        // Sweep of table shapes: duplicates, entries at or beyond L
        for (int cfg = 0; cfg < 4; cfg++) begin
            enable = 1'b0;
            @(negedge clk);
            chk(ev_valid == 1'b0, "R1 disable clears", ev_valid, 0);
            m_len = 5 + 3 * cfg;
            m_n   = cfg + 3;
            m_rst = 8'hA0 + cfg;
            for (int i = 0; i < m_n; i++) begin
                m_time[i] = (i * (cfg + 1)) / 2;
                m_code[i] = 8'h40 + cfg * 16 + i;
            end
            if (cfg % 2 == 1) m_time[m_n - 1] = m_len;        // R5 never emitted
            for (int i = 0; i < m_n; i++) write_entry(i, m_time[i], m_code[i]);
            cycle_len = 32'(m_len); reset_code = 8'(m_rst); num_entries = 7'(m_n);
            ev_ready = 1'b1;
            enable = 1'b1;
            write_entry(0, 0, 8'hFF);                          // R9 ignored
            m_now = 0; m_ptr = 0;
            for (int k = 0; k < 3 * (m_len + 1); k++) model_tick();
        end

        // Back-pressure and reset/entry collision
        enable = 1'b0;
        @(negedge clk);
        write_entry(0, 1, 8'h11);
        write_entry(1, 2, 8'h22);
        cycle_len = 32'd6; reset_code = 8'h5A; num_entries = 7'd2;
        ev_ready = 1'b0;
        enable = 1'b1;
        pulse();                                               // count 0
        chk(ev_valid == 1'b0, "R3 nothing due at 0", ev_valid, 0);
        pulse();                                               // count 1
        chk(ev_valid && ev_code == 8'h11, "R3 entry at 1", ev_code, 8'h11);
        pulse();                                               // count 2, blocked
        chk(ev_valid && ev_code == 8'h11, "R6 hold while not ready", ev_code, 8'h11);
        ev_ready = 1'b1;
        @(negedge clk);
        chk(ev_valid == 1'b0, "R7 no load without tick", ev_valid, 0);
        pulse();                                               // count 3
        chk(ev_valid && ev_code == 8'h22, "R7 stalled entry late", ev_code, 8'h22);
        ev_ready = 1'b0;
        pulse(); pulse();                                      // counts 4,5
        pulse();                                               // count 6 = end
        chk(ev_valid && ev_code == 8'h22, "R8 old event kept at end", ev_code, 8'h22);
        ev_ready = 1'b1;
        @(negedge clk);
        chk(ev_valid && ev_code == 8'h5A, "R8 pending reset released", ev_code, 8'h5A);
        @(negedge clk);
        chk(ev_valid == 1'b0, "R6 reset consumed", ev_valid, 0);
        pulse();                                               // new count 0
        chk(ev_valid == 1'b0, "R2 restart at 0", ev_valid, 0);
        pulse();                                               // new count 1
        chk(ev_valid && ev_code == 8'h11, "R2/R5 pointer restarted", ev_code, 8'h11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule